// File: doc/BRIEF.md
# DRAM Bank and Rank Command Scheduler

This block sits between the request queue of a small DDRx memory controller and the command bus of a single rank. Each bank gets an open-row register and three saturating down-counters: activate-to-column, activate-to-precharge and precharge-to-activate. The rank gets one more counter for its shared data I/O window. A request (bank, row, column, read/write) arrives on a valid/ready handshake. The block classifies it against the bank's open row and emits the precharge, activate and column commands it needs, one command per cycle. It also pulses a data-valid flag in the cycle when read data would reach the bus.

A request whose row is already open is a hit. It is accepted only in the cycle its column command can issue, and that command goes out in the same cycle. Any other request (closed bank or different row) is taken into a single pending slot. The slot then walks through precharge, activate and column as each timing window expires. All timing values and the DDR generation are parameters.

Top module: `dram_bank_sched`

## Requirements
- R1: After reset every bank is closed, no command is issued (`cmd_type` = 0), `rd_data_valid` is low and `req_ready` is high. The first request to any bank therefore issues an activate with no precharge.
- R2: A request to a closed bank is taken into the pending slot in its acceptance cycle A. The activate issues in cycle A+1 when the precharge window allows it. Its column command issues exactly T_RCD cycles after the activate if the rank window is free, and never earlier.
- R3: `rd_data_valid` is high for one cycle exactly T_CAS cycles after each read column command, and at no other time.
- R4: For a request to a different row of an open bank, the precharge issues no earlier than T_RAS cycles after that bank's activate. The new activate issues exactly T_RP cycles after the precharge. The column command issues T_RCD cycles after that activate, or later if the rank window is still busy.
- R5: A hit is accepted and its column command issued in the same cycle, with no precharge or activate. Every column command carries the row that is open in its bank.
- R6: Successive column commands are at least tCCD cycles apart. tCCD is 1, 2 or 4 cycles for DDR_GEN = 1, 2 or 3.
- R7: At most one command issues per cycle. A pending column command wins over a new hit. A new hit's column command wins over a pending precharge or activate, which then issues one cycle later.
- R8: `req_ready` stays low for a hit while the rank window or its bank's activate-to-column window is busy, or while a pending request targets the same bank. The request is held until it can issue.
- R9: At most one non-hit request is pending. A second one is accepted only in the cycle after the first one's column command.
- R10: `cmd_type` encodes 0 none, 1 precharge, 2 activate, 3 read, 4 write, and `cmd_valid` is high exactly when `cmd_type` is non-zero. Write column commands never raise `rd_data_valid`.
- R11: Every accepted request receives exactly one column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted in this cycle when valid |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_write | input | 1 | 1 for write, 0 for read |
| cmd_valid | output | 1 | A command issues in this cycle |
| cmd_type | output | 3 | Command code (see R10) |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_row | output | ROW_W | Row of the command |
| cmd_col | output | COL_W | Column of the command |
| rd_data_valid | output | 1 | Read data on the bus in this cycle |

## Verification
The bench aims at the exact edges of each timing window. These are the column T_RCD cycles after an activate, the precharge held back until T_RAS, the activate T_RP cycles after the precharge, and a second hit that must wait a full tCCD. An off-by-one counter load would shift one of these cycles and show up directly. A broken hit detector would issue a column to a row that is not open, or re-activate a row that is already open. A wrong arbitration order would let a pending activate block a ready hit. A faulty data-valid delay line would raise the flag in the wrong cycle or after writes. Random mixed traffic with few rows provokes hits, conflicts and rank collisions together, and every command is checked against an independent legality model.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_PRE = 3'd1,
    CMD_ACT = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } dram_cmd_e;

  // Rank I/O burst window in controller cycles for a DDR generation.
  function automatic int unsigned ccd_cycles(input int unsigned gen);
    if (gen <= 1) return 1;
    else if (gen == 2) return 2;
    else return 4;
  endfunction

  // Counter load value so that a dependent command is legal exactly
  // t cycles after the command that loads it.
  function automatic int unsigned window_load(input int unsigned t);
    return (t == 0) ? 0 : t - 1;
  endfunction

endpackage

// File: rtl/dbs_bank_timer.sv
module dbs_bank_timer #(
  parameter int ROW_W = 8,
  parameter int CNT_W = 8,
  parameter int T_RCD = 3,
  parameter int T_RAS = 6,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rcd_ok_o,
  output logic             ras_ok_o,
  output logic             rp_ok_o
);
  import dbs_pkg::*;

  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(window_load(T_RCD));
  localparam logic [CNT_W-1:0] RAS_LD = CNT_W'(window_load(T_RAS));
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(window_load(T_RP));

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] rcd_q, ras_q, rp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rp_q   <= '0;
    end else begin
      rcd_q <= (rcd_q != '0) ? rcd_q - 1'b1 : '0;
      ras_q <= (ras_q != '0) ? ras_q - 1'b1 : '0;
      rp_q  <= (rp_q  != '0) ? rp_q  - 1'b1 : '0;
      if (act_i) begin
        open_q <= 1'b1;
        row_q  <= row_i;
        rcd_q  <= RCD_LD;
        ras_q  <= RAS_LD;
      end
      if (pre_i) begin
        open_q <= 1'b0;
        rp_q   <= RP_LD;
      end
    end
  end

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign rcd_ok_o = (rcd_q == '0);
  assign ras_ok_o = (ras_q == '0);
  assign rp_ok_o  = (rp_q == '0);

  assert_act_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> (!open_q && rp_q == '0));
  assert_pre_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pre_i |-> (open_q && ras_q == '0));
  assert_col_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> (open_q && rcd_q == '0));
  assert_one_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_i, pre_i, col_i}));

endmodule

// File: rtl/dbs_rank_io.sv
module dbs_rank_io #(
  parameter int CNT_W   = 8,
  parameter int DDR_GEN = 3,
  parameter int T_CAS   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic col_i,
  input  logic rd_i,
  output logic free_o,
  output logic rd_valid_o
);
  import dbs_pkg::*;

  localparam logic [CNT_W-1:0] CCD_LD = CNT_W'(window_load(ccd_cycles(DDR_GEN)));

  logic [CNT_W-1:0] ccd_q;
  logic [T_CAS-1:0] dv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ccd_q <= '0;
      dv_q  <= '0;
    end else begin
      ccd_q <= col_i ? CCD_LD : ((ccd_q != '0) ? ccd_q - 1'b1 : '0);
      dv_q  <= T_CAS'({dv_q, col_i & rd_i});
    end
  end

  assign free_o     = (ccd_q == '0);
  assign rd_valid_o = dv_q[T_CAS-1];

  assert_rank_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> ccd_q == '0);
  assert_rd_only_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |-> col_i);

endmodule

// File: rtl/dram_bank_sched.sv
module dram_bank_sched #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 8,
  parameter int COL_W     = 6,
  parameter int CNT_W     = 8,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 4,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int DDR_GEN   = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_write,
  output logic              cmd_valid,
  output logic [2:0]        cmd_type,
  output logic [BANK_W-1:0] cmd_bank,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col,
  output logic              rd_data_valid
);
  import dbs_pkg::*;

  logic [NUM_BANKS-1:0] bank_open, rcd_ok, ras_ok, rp_ok;
  logic [NUM_BANKS-1:0] act_v, pre_v, col_v;
  logic [ROW_W-1:0]     bank_row [NUM_BANKS];
  logic                 io_free;

  // Pending slot for a request that needs precharge and/or activate.
  logic              pnd_v, pnd_wr;
  logic [BANK_W-1:0] pnd_bank;
  logic [ROW_W-1:0]  pnd_row;
  logic [COL_W-1:0]  pnd_col;

  // Named internal events.
  logic in_row_match, in_hit_req, in_blocked, miss_accept;
  logic pnd_open, pnd_match;
  logic pnd_col_go, in_col_go, pnd_pre_go, pnd_act_go;
  logic col_is_rd;

  always_comb begin
    in_row_match = bank_open[req_bank] && (bank_row[req_bank] == req_row);
    in_hit_req   = req_valid && in_row_match;
    in_blocked   = pnd_v && (pnd_bank == req_bank);
    pnd_open     = bank_open[pnd_bank];
    pnd_match    = pnd_open && (bank_row[pnd_bank] == pnd_row);

    pnd_col_go = pnd_v && pnd_match && rcd_ok[pnd_bank] && io_free;
    in_col_go  = in_hit_req && !in_blocked && rcd_ok[req_bank] && io_free && !pnd_col_go;
    pnd_pre_go = pnd_v && pnd_open && !pnd_match && ras_ok[pnd_bank] && !in_col_go;
    pnd_act_go = pnd_v && !pnd_open && rp_ok[pnd_bank] && !in_col_go;

    miss_accept = req_valid && !in_row_match && !pnd_v;
    req_ready   = in_col_go || (!in_hit_req && !pnd_v);
  end

  always_comb begin
    cmd_type  = CMD_NOP;
    cmd_bank  = pnd_bank;
    cmd_row   = pnd_row;
    cmd_col   = pnd_col;
    col_is_rd = 1'b0;
    if (pnd_col_go) begin
      cmd_type  = pnd_wr ? CMD_WR : CMD_RD;
      col_is_rd = !pnd_wr;
    end else if (in_col_go) begin
      cmd_type  = req_write ? CMD_WR : CMD_RD;
      cmd_bank  = req_bank;
      cmd_row   = req_row;
      cmd_col   = req_col;
      col_is_rd = !req_write;
    end else if (pnd_pre_go) begin
      cmd_type = CMD_PRE;
    end else if (pnd_act_go) begin
      cmd_type = CMD_ACT;
    end
    cmd_valid = (cmd_type != CMD_NOP);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pnd_v    <= 1'b0;
      pnd_wr   <= 1'b0;
      pnd_bank <= '0;
      pnd_row  <= '0;
      pnd_col  <= '0;
    end else if (miss_accept) begin
      pnd_v    <= 1'b1;
      pnd_wr   <= req_write;
      pnd_bank <= req_bank;
      pnd_row  <= req_row;
      pnd_col  <= req_col;
    end else if (pnd_col_go) begin
      pnd_v <= 1'b0;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_v[b] = pnd_act_go && (cmd_type == CMD_ACT) && (pnd_bank == BANK_W'(b));
    assign pre_v[b] = pnd_pre_go && (cmd_type == CMD_PRE) && (pnd_bank == BANK_W'(b));
    assign col_v[b] = (pnd_col_go && (pnd_bank == BANK_W'(b))) ||
                      (in_col_go && (req_bank == BANK_W'(b)));

    dbs_bank_timer #(
      .ROW_W(ROW_W), .CNT_W(CNT_W),
      .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(act_v[b]), .pre_i(pre_v[b]), .col_i(col_v[b]),
      .row_i(pnd_row),
      .open_o(bank_open[b]), .row_o(bank_row[b]),
      .rcd_ok_o(rcd_ok[b]), .ras_ok_o(ras_ok[b]), .rp_ok_o(rp_ok[b])
    );
  end

  dbs_rank_io #(
    .CNT_W(CNT_W), .DDR_GEN(DDR_GEN), .T_CAS(T_CAS)
  ) u_rank (
    .clk(clk), .rst_n(rst_n),
    .col_i(pnd_col_go || in_col_go), .rd_i(col_is_rd),
    .free_o(io_free), .rd_valid_o(rd_data_valid)
  );

  assert_hit_no_rowcmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_col_go |-> (act_v == '0 && pre_v == '0));
  assert_single_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pnd_v && !pnd_col_go) |=> (pnd_v && $stable(pnd_bank) && $stable(pnd_row)));
  assert_hit_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_hit_req && !io_free) |-> !req_ready);

endmodule

// File: tb/tb_dram_bank_sched.sv
module tb_dram_bank_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, RW = 8, CW = 6;
  localparam int T_RCD = 3, T_CAS = 4, T_RAS = 6, T_RP = 3, GEN = 3;
  localparam int WATCHDOG = 20000;

  function automatic int tccd_of(input int gen);
    case (gen)
      1: return 1;
      2: return 2;
      default: return 4;
    endcase
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int TCCD = (GEN == 1) ? 1 : (GEN == 2) ? 2 : 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [1:0] req_bank = 0;
  logic [RW-1:0] req_row = 0;
  logic [CW-1:0] req_col = 0;
  logic cmd_valid, rd_data_valid;
  logic [2:0] cmd_type;
  logic [1:0] cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CW-1:0] cmd_col;

  dram_bank_sched #(.NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW), .CNT_W(8),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP), .DDR_GEN(GEN)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_col(cmd_col), .rd_data_valid(rd_data_valid));

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0, n_checks = 0, n_fail = 0, accepted = 0, col_count = 0, act_count = 0;
  int last_col = -1000, last_dv = -1000;
  bit done = 0;
  bit m_open [NB];
  int m_row [NB], m_act [NB], m_pre [NB];
  bit exp_dv [256];

  always @(posedge clk) cyc = cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  initial begin
    for (int b = 0; b < NB; b++) begin
      m_open[b] = 0; m_row[b] = 0; m_act[b] = -1000; m_pre[b] = -1000;
    end
    for (int i = 0; i < 256; i++) exp_dv[i] = 0;
  end

  // Independent legality model of the command stream.
  always @(negedge clk) if (rst_n && !done) begin
    check(cmd_valid == (cmd_type != 3'd0), "R10", cmd_valid, cmd_type != 3'd0);
    if (cmd_valid) begin
      case (cmd_type)
        3'd1: begin
          check(m_open[cmd_bank] && cyc - m_act[cmd_bank] >= T_RAS, "R4 pre",
                cyc - m_act[cmd_bank], T_RAS);
          m_open[cmd_bank] = 0; m_pre[cmd_bank] = cyc;
        end
        3'd2: begin
          check(!m_open[cmd_bank] && cyc - m_pre[cmd_bank] >= T_RP, "R4 act",
                cyc - m_pre[cmd_bank], T_RP);
          m_open[cmd_bank] = 1; m_row[cmd_bank] = cmd_row; m_act[cmd_bank] = cyc;
          act_count++;
        end
        3'd3, 3'd4: begin
          check(m_open[cmd_bank] && cyc - m_act[cmd_bank] >= T_RCD, "R2 col",
                cyc - m_act[cmd_bank], T_RCD);
          check(m_open[cmd_bank] && m_row[cmd_bank] == cmd_row, "R5 row",
                cmd_row, m_row[cmd_bank]);
          check(cyc - last_col >= tccd_of(GEN), "R6", cyc - last_col, tccd_of(GEN));
          last_col = cyc; col_count++;
          if (cmd_type == 3'd3) exp_dv[(cyc + T_CAS) % 256] = 1;
        end
        default: check(0, "R10 code", cmd_type, 0);
      endcase
    end
    if (exp_dv[cyc % 256] || rd_data_valid)
      check(rd_data_valid == exp_dv[cyc % 256], "R3", rd_data_valid, exp_dv[cyc % 256]);
    exp_dv[cyc % 256] = 0;
    if (rd_data_valid) last_dv = cyc;
  end

  // Called just after a rising edge; returns the acceptance cycle.
  task automatic send(input int b, input int row, input int col, input bit wr, output int acc);
    req_valid = 1; req_bank = 2'(b); req_row = RW'(row); req_col = CW'(col); req_write = wr;
    forever begin
      @(negedge clk);
      if (req_ready) begin
        acc = cyc; accepted++;
        @(posedge clk); #1;
        req_valid = 0;
        break;
      end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      done = 1; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int a, h, a1, a2, c1, pe, ae, ce, h1, h2, acts, r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(!cmd_valid && cmd_type == 0, "R1 cmd", cmd_type, 0);
    check(!rd_data_valid, "R1 dv", rd_data_valid, 0);
    check(req_ready, "R1 ready", req_ready, 1);
    @(posedge clk); #1;

    // R2/R3: closed bank read.
    send(0, 5, 1, 0, a); idle(15);
    check(m_act[0] == a + 1, "R2 act cycle", m_act[0], a + 1);
    check(last_col == a + 1 + T_RCD, "R2 col cycle", last_col, a + 1 + T_RCD);
    check(last_dv == a + 1 + T_RCD + T_CAS, "R3 dv cycle", last_dv, a + 1 + T_RCD + T_CAS);

    // R5: hit issues at once.
    acts = act_count;
    send(0, 5, 2, 0, h); idle(10);
    check(last_col == h, "R5 hit col", last_col, h);
    check(act_count == acts, "R5 no act", act_count, acts);

    // R4/R9/R10: conflict right after activate, write.
    send(1, 1, 0, 0, a1); send(1, 2, 3, 1, a2);
    c1 = a1 + 1 + T_RCD;
    check(a2 == c1 + 1, "R9 second miss", a2, c1 + 1);
    pe = imax(a2 + 1, a1 + 1 + T_RAS); ae = pe + T_RP; ce = imax(ae + T_RCD, c1 + TCCD);
    idle(25);
    check(m_pre[1] == pe, "R4 pre cycle", m_pre[1], pe);
    check(m_act[1] == ae, "R4 act cycle", m_act[1], ae);
    check(last_col == ce, "R4 col cycle", last_col, ce);
    check(last_dv == c1 + T_CAS, "R10 write no dv", last_dv, c1 + T_CAS);

    // R6/R8: back-to-back hits wait for the rank window.
    send(0, 5, 4, 0, h1); send(1, 2, 5, 0, h2);
    check(h2 - h1 == tccd_of(GEN), "R6 R8 hit spacing", h2 - h1, tccd_of(GEN));
    idle(20);

    // R7: new hit beats pending activate.
    send(2, 7, 6, 0, a); send(0, 5, 7, 1, h); idle(15);
    check(h == a + 1, "R7 hit first", h, a + 1);
    check(m_act[2] == a + 2, "R7 act delayed", m_act[2], a + 2);

    // Random mixed traffic.
    r = $urandom(32'd2024);
    for (int i = 0; i < 300; i++) begin
      int g;
      send(int'($urandom_range(0, 3)), int'($urandom_range(0, 2)),
           int'($urandom_range(0, 63)), 1'($urandom_range(0, 1)), a);
      g = int'($urandom_range(0, 2));
      if (g > 0) idle(g);
    end
    idle(60);
    check(col_count == accepted, "R11 one column per request", col_count, accepted);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule